// File: doc/BRIEF.md
# Interline CCD Drive Timing Generator

This block produces every logic-level drive and marker signal that an interline-transfer CCD with field readout and an electronic shutter needs. It runs from one clock at the pixel rate. A pixel counter and a line/field counter walk a fixed sensor map. That map is made of horizontal blanking, dummy columns, optical-black columns and effective columns, and vertically of a dummy line (even fields only), optical-black lines, effective lines and vertical blanking. From the counters the block decodes line and field markers, the two horizontal shift clocks, the reset-gate strobe, the four vertical phases, the two readout gates and the substrate drain pulse. It also gives a two-bit code that classifies the pixel currently being shifted out.

Each field ends with a readout line. On that line the vertical phases rest, and two gate pulses move charge from the photodiodes into the vertical register. The pulse that comes first depends on the field. On every earlier line of the field a drain pulse empties the photodiodes, except on the last `shut_lines` lines before readout. The shutter input therefore sets the charge storage time in whole lines. Level shifting and the analog side lie downstream of this block.

Top module: `ccd_timing_gen`

## Requirements
- R1: A synchronous active-low reset places the generator at pixel 0 of line 0 of the odd field (`fld` = 0). It holds it there while `rst_n` is low, and counting resumes from that point on the first clock with `rst_n` high.
- R2: A line lasts HBLK+HDUM+HFOB+HEFF+HROB pixels, in this order: HBLK blanking, HDUM dummy, HFOB optical-black, HEFF effective and HROB optical-black pixels. `pix_region` codes are 0 blank, 1 dummy, 2 optical black and 3 effective. Within a pixel the code with the higher priority wins: blank over dummy, dummy over optical black, optical black over effective.
- R3: `hd` is high for the first HD_W pixels of every line. `blk` is high during horizontal blanking and for the whole of every vertical-blanking line.
- R4: `hclk2` is always the complement of `hclk1`. In blanking `hclk1`=1. In the shift region `hclk1` is 1 on the first shifted pixel and toggles on every pixel. `rst_gate` is high exactly on shifted pixels.
- R5: A field starts with VFOB/2 optical-black lines, then VEFF/2 effective lines, then VROB/2 optical-black lines, and ends with vertical blanking. In the even field these come after one dummy line (line 0), and the even field has one line more than the odd field.
- R6: `fld` is 0 in the odd field (FRAME_LINES/2 lines) and 1 in the even field (the remaining lines). It changes only at the start of a line.
- R7: `vd` is high for the first VD_LINES lines of each field's vertical blanking, and never outside it.
- R8: `vph` (bit 0 = phase 1) rests at 4'b0011. On every line except the readout line, pixels VT_START onward step it through 4'b0110, 4'b1100 and 4'b1001, each for VT_STEP pixels, and then back to 4'b0011. It is static at all other times.
- R9: The last line of each field is the readout line. It carries two RD_W-pixel gate pulses, starting at RD_START and at RD_START+RD_W+RD_GAP. `xfer_gate[0]` comes first in the odd field and `xfer_gate[1]` comes first in the even field. No gate fires on any other line.
- R10: `drain` pulses for SUB_W pixels from SUB_START on every line whose distance in lines to the readout line exceeds `shut_lines`. It never pulses on the readout line.
- R11: With `shut_lines` = 0, `drain` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shut_lines | input | SHUT_W | Storage time in lines before readout; 0 disables the shutter |
| hd | output | 1 | Line-start marker |
| vd | output | 1 | Field marker in vertical blanking |
| blk | output | 1 | Combined blanking |
| fld | output | 1 | Field flag, 0 odd, 1 even |
| hclk1 | output | 1 | Horizontal shift clock, phase 1 |
| hclk2 | output | 1 | Horizontal shift clock, phase 2 |
| rst_gate | output | 1 | Output-node reset strobe |
| vph | output | 4 | Vertical phases, bit 0 = phase 1 |
| xfer_gate | output | 2 | Readout gates on phase 1 [0] and phase 3 [1] |
| drain | output | 1 | Substrate drain (shutter) pulse |
| pix_region | output | 2 | Pixel class of the current pixel |

## Verification
The bench walks whole frames, so it crosses both field lengths and the dummy line that only even fields carry. A generator that used one length for both fields, or that placed the dummy line in the odd field, would shift every later region code by one line. It checks the readout order in both fields, because a design that fixed the order would swap the gates in one field. It sweeps `shut_lines` through 0, 1, a mid value, the largest distance to readout and a value above any field. A comparison off by one would show up as an extra or a missing drain line next to readout. A reset in the middle of a line tests that both counters and the field flag restart together.

// File: rtl/ccd_tg_pkg.sv
// Shared types and helpers for the CCD timing generator.
// Assumes: region codes are consumed downstream as a 2-bit field.
package ccd_tg_pkg;

    typedef enum logic [1:0] {
        RG_BLANK = 2'd0,
        RG_DUMMY = 2'd1,
        RG_OB    = 2'd2,
        RG_EFF   = 2'd3
    } region_t;

    localparam logic [3:0] VPH_REST = 4'b0011;

    // Vertical phase pattern after s steps from rest (bit 0 = phase 1).
    function automatic logic [3:0] vph_rot(input logic [1:0] s);
        case (s)
            2'd0:    return 4'b0011;
            2'd1:    return 4'b0110;
            2'd2:    return 4'b1100;
            default: return 4'b1001;
        endcase
    endfunction

endpackage

// File: rtl/ccd_hcount.sv
// Pixel counter and horizontal decode.
// Counts 0..HTOT-1 per line, emits line end, line marker, horizontal
// blanking, the column class and the horizontal shift clocks.
// Assumes: HD_W <= HBLK, HW wide enough for HTOT-1.
module ccd_hcount
    import ccd_tg_pkg::*;
#(
    parameter int HBLK = 77,
    parameter int HDUM = 22,
    parameter int HFOB = 3,
    parameter int HEFF = 768,
    parameter int HROB = 40,
    parameter int HD_W = 8,
    parameter int HW   = $clog2(HBLK + HDUM + HFOB + HEFF + HROB)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic          line_end,
    output logic          hblank,
    output logic          hd,
    output region_t       hreg,
    output logic          hclk1,
    output logic          hclk2,
    output logic          rst_gate
);

    localparam int HTOT = HBLK + HDUM + HFOB + HEFF + HROB;
    localparam logic [HW-1:0] LAST = HW'(HTOT - 1);
    localparam logic [HW-1:0] D0   = HW'(HBLK);
    localparam logic [HW-1:0] F0   = HW'(HBLK + HDUM);
    localparam logic [HW-1:0] E0   = HW'(HBLK + HDUM + HFOB);
    localparam logic [HW-1:0] R0   = HW'(HBLK + HDUM + HFOB + HEFF);
    localparam logic [HW-1:0] HDE  = HW'(HD_W);
    localparam logic          BPAR = ((HBLK % 2) != 0);

    logic [HW-1:0] hcnt_q;

    // Pixel counter, wraps at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hcnt_q <= '0;
        else if (line_end)
            hcnt_q <= '0;
        else
            hcnt_q <= hcnt_q + 1'b1;
    end

    // Line-level markers.
    always_comb begin
        hcnt     = hcnt_q;
        line_end = (hcnt_q == LAST);
        hblank   = (hcnt_q < D0);
        hd       = (hcnt_q < HDE);
    end

    // Column class along the line.
    always_comb begin
        if (hcnt_q < D0)      hreg = RG_BLANK;
        else if (hcnt_q < F0) hreg = RG_DUMMY;
        else if (hcnt_q < E0) hreg = RG_OB;
        else if (hcnt_q < R0) hreg = RG_EFF;
        else                  hreg = RG_OB;
    end

    // Shift clocks: idle in blanking, toggle per pixel while shifting.
    always_comb begin
        hclk1    = hblank | (hcnt_q[0] == BPAR);
        hclk2    = ~hclk1;
        rst_gate = ~hblank;
    end

endmodule

// File: rtl/ccd_vcount.sv
// Line and field counter with vertical decode.
// Odd field has FRAME_LINES/2 lines, even field the rest, beginning with
// one dummy line. Row counts are halved because field readout merges rows.
// Assumes: data lines fit in the odd field with at least VD_LINES spare.
module ccd_vcount
    import ccd_tg_pkg::*;
#(
    parameter int FRAME_LINES = 525,
    parameter int VFOB        = 12,
    parameter int VEFF        = 494,
    parameter int VROB        = 2,
    parameter int VD_LINES    = 3,
    parameter int LW          = $clog2(FRAME_LINES - FRAME_LINES / 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    output logic          fld,
    output logic          last_line,
    output logic          vblank,
    output logic          vd,
    output region_t       vreg,
    output logic [LW-1:0] lines_left
);

    localparam int ODD_LEN  = FRAME_LINES / 2;
    localparam int EVEN_LEN = FRAME_LINES - ODD_LEN;
    localparam int FOB_L    = VFOB / 2;
    localparam int EFF_L    = VEFF / 2;
    localparam int ROB_L    = VROB / 2;
    localparam int DATA_L   = FOB_L + EFF_L + ROB_L;

    logic [LW-1:0] vln_q;
    logic          fld_q;
    logic [LW-1:0] flen_m1;
    logic [LW-1:0] first;
    logic [LW-1:0] dline;

    // Line counter and field flag, advanced at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vln_q <= '0;
            fld_q <= 1'b0;
        end else if (line_end) begin
            if (last_line) begin
                vln_q <= '0;
                fld_q <= ~fld_q;
            end else begin
                vln_q <= vln_q + 1'b1;
            end
        end
    end

    // Field geometry for the current field.
    always_comb begin
        flen_m1    = fld_q ? LW'(EVEN_LEN - 1) : LW'(ODD_LEN - 1);
        first      = LW'(fld_q);
        dline      = vln_q - first;
        last_line  = (vln_q == flen_m1);
        lines_left = flen_m1 - vln_q;
        fld        = fld_q;
    end

    // Line class within the field.
    always_comb begin
        if (vln_q < first)                       vreg = RG_DUMMY;
        else if (dline < LW'(FOB_L))             vreg = RG_OB;
        else if (dline < LW'(FOB_L + EFF_L))     vreg = RG_EFF;
        else if (dline < LW'(DATA_L))            vreg = RG_OB;
        else                                     vreg = RG_BLANK;
    end

    // Vertical blanking and the field marker at its start.
    always_comb begin
        vblank = (vreg == RG_BLANK);
        vd     = vblank && ((dline - LW'(DATA_L)) < LW'(VD_LINES));
    end

endmodule

// File: rtl/ccd_vdrive.sv
// Vertical phase, readout gate and drain pulse decode (combinational).
// All windows are pixel positions inside horizontal blanking.
// Assumes: windows lie below HBLK and do not overlap the line marker logic.
module ccd_vdrive
    import ccd_tg_pkg::*;
#(
    parameter int HW        = 10,
    parameter int LW        = 9,
    parameter int SHUT_W    = 9,
    parameter int VT_START  = 4,
    parameter int VT_STEP   = 8,
    parameter int RD_START  = 4,
    parameter int RD_W      = 32,
    parameter int RD_GAP    = 4,
    parameter int SUB_START = 40,
    parameter int SUB_W     = 20
) (
    input  logic [HW-1:0]     hcnt,
    input  logic              last_line,
    input  logic              fld,
    input  logic [LW-1:0]     lines_left,
    input  logic [SHUT_W-1:0] shut_lines,
    output logic [3:0]        vph,
    output logic [1:0]        xfer_gate,
    output logic              drain
);

    localparam int RD2_START = RD_START + RD_W + RD_GAP;

    logic [3:0] in_step;
    logic       win_a;
    logic       win_b;
    logic       win_sub;

    // One comparator pair per transfer step.
    for (genvar k = 0; k < 4; k++) begin : g_step
        assign in_step[k] = (hcnt >= HW'(VT_START + k * VT_STEP)) &&
                            (hcnt <  HW'(VT_START + (k + 1) * VT_STEP));
    end

    // Phase pattern: rest, or the step selected by the pixel position.
    always_comb begin
        vph = VPH_REST;
        if (!last_line) begin
            for (int k = 0; k < 4; k++) begin
                if (in_step[k]) vph = vph_rot(2'(k + 1));
            end
        end
    end

    // Readout gate windows and field-dependent order.
    always_comb begin
        win_a = (hcnt >= HW'(RD_START))  && (hcnt < HW'(RD_START + RD_W));
        win_b = (hcnt >= HW'(RD2_START)) && (hcnt < HW'(RD2_START + RD_W));
        if (!last_line)
            xfer_gate = 2'b00;
        else if (fld)
            xfer_gate = {win_a, win_b};
        else
            xfer_gate = {win_b, win_a};
    end

    // Drain pulse on lines farther from readout than the shutter setting.
    always_comb begin
        win_sub = (hcnt >= HW'(SUB_START)) && (hcnt < HW'(SUB_START + SUB_W));
        drain   = win_sub && (shut_lines != '0) &&
                  (32'(lines_left) > 32'(shut_lines));
    end

endmodule

// File: rtl/ccd_timing_gen.sv
// Top of the CCD timing generator: ties the pixel counter, the line/field
// counter and the vertical drive decode, and merges the pixel class.
// Assumes: one clock per pixel; all outputs decode directly from counters.
module ccd_timing_gen
    import ccd_tg_pkg::*;
#(
    parameter int HBLK        = 77,
    parameter int HDUM        = 22,
    parameter int HFOB        = 3,
    parameter int HEFF        = 768,
    parameter int HROB        = 40,
    parameter int HD_W        = 8,
    parameter int FRAME_LINES = 525,
    parameter int VFOB        = 12,
    parameter int VEFF        = 494,
    parameter int VROB        = 2,
    parameter int VD_LINES    = 3,
    parameter int VT_START    = 4,
    parameter int VT_STEP     = 8,
    parameter int RD_START    = 4,
    parameter int RD_W        = 32,
    parameter int RD_GAP      = 4,
    parameter int SUB_START   = 40,
    parameter int SUB_W       = 20,
    parameter int SHUT_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SHUT_W-1:0] shut_lines,
    output logic              hd,
    output logic              vd,
    output logic              blk,
    output logic              fld,
    output logic              hclk1,
    output logic              hclk2,
    output logic              rst_gate,
    output logic [3:0]        vph,
    output logic [1:0]        xfer_gate,
    output logic              drain,
    output logic [1:0]        pix_region
);

    localparam int HW = $clog2(HBLK + HDUM + HFOB + HEFF + HROB);
    localparam int LW = $clog2(FRAME_LINES - FRAME_LINES / 2);

    logic [HW-1:0] hcnt;
    logic          line_end;
    logic          hblank;
    region_t       hreg;
    logic          last_line;
    logic          vblank;
    region_t       vreg;
    logic [LW-1:0] lines_left;
    region_t       region;

    ccd_hcount #(
        .HBLK(HBLK), .HDUM(HDUM), .HFOB(HFOB), .HEFF(HEFF), .HROB(HROB),
        .HD_W(HD_W), .HW(HW)
    ) u_hcount (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .line_end(line_end),
        .hblank(hblank), .hd(hd), .hreg(hreg), .hclk1(hclk1),
        .hclk2(hclk2), .rst_gate(rst_gate)
    );

    ccd_vcount #(
        .FRAME_LINES(FRAME_LINES), .VFOB(VFOB), .VEFF(VEFF), .VROB(VROB),
        .VD_LINES(VD_LINES), .LW(LW)
    ) u_vcount (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .fld(fld),
        .last_line(last_line), .vblank(vblank), .vd(vd), .vreg(vreg),
        .lines_left(lines_left)
    );

    ccd_vdrive #(
        .HW(HW), .LW(LW), .SHUT_W(SHUT_W), .VT_START(VT_START),
        .VT_STEP(VT_STEP), .RD_START(RD_START), .RD_W(RD_W),
        .RD_GAP(RD_GAP), .SUB_START(SUB_START), .SUB_W(SUB_W)
    ) u_vdrive (
        .hcnt(hcnt), .last_line(last_line), .fld(fld),
        .lines_left(lines_left), .shut_lines(shut_lines), .vph(vph),
        .xfer_gate(xfer_gate), .drain(drain)
    );

    // Merge column and line class: blank > dummy > optical black > effective.
    always_comb begin
        if (hreg == RG_BLANK || vreg == RG_BLANK)      region = RG_BLANK;
        else if (hreg == RG_DUMMY || vreg == RG_DUMMY) region = RG_DUMMY;
        else if (hreg == RG_OB || vreg == RG_OB)       region = RG_OB;
        else                                           region = RG_EFF;
    end

    // Combined blanking and output class.
    always_comb begin
        blk        = hblank | vblank;
        pix_region = region;
    end

endmodule

// File: rtl/ccd_timing_chk.sv
// Property checker for ccd_timing_gen, attached by bind below.
module ccd_timing_chk #(
    parameter int SHUT_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SHUT_W-1:0] shut_lines,
    input logic              hd,
    input logic              vd,
    input logic              blk,
    input logic              fld,
    input logic              hclk1,
    input logic              hclk2,
    input logic              rst_gate,
    input logic [3:0]        vph,
    input logic [1:0]        xfer_gate,
    input logic              drain,
    input logic [1:0]        pix_region
);

    assert_eff_shifting_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_region == 2'd3) |-> (rst_gate && !blk));

    assert_idle_at_line_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hd |-> (hclk1 && !hclk2 && !rst_gate));

    assert_hclk_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_gate && $past(rst_gate)) |-> (hclk1 != $past(hclk1)));

    assert_field_change_at_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fld != $past(fld)) |-> hd);

    assert_vd_in_blanking_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vd |-> blk);

    assert_vph_static_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_gate && $past(rst_gate)) |-> $stable(vph));

    assert_vph_two_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vph) == 2);

    assert_gate_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_gate));

    assert_gate_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_gate != 2'b00) |-> (vph == 4'b0011));

    assert_no_drain_at_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(drain && (xfer_gate != 2'b00)));

    assert_shutter_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_lines == '0) |-> !drain);

endmodule

bind ccd_timing_gen ccd_timing_chk #(.SHUT_W(SHUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .shut_lines(shut_lines), .hd(hd), .vd(vd),
    .blk(blk), .fld(fld), .hclk1(hclk1), .hclk2(hclk2),
    .rst_gate(rst_gate), .vph(vph), .xfer_gate(xfer_gate), .drain(drain),
    .pix_region(pix_region)
);

// File: tb/tb_ccd_timing_gen.sv
`timescale 1ns/1ps
module tb_ccd_timing_gen;

    localparam int HBLK = 12, HDUM = 2, HFOB = 1, HEFF = 8, HROB = 3, HD_W = 2;
    localparam int FRAME = 21, VFOB = 4, VEFF = 10, VROB = 2, VD_L = 1;
    localparam int VT_S = 1, VT_P = 2, RD_S = 1, RD_W = 3, RD_G = 1;
    localparam int SUB_S = 9, SUB_W = 2, SHUT_W = 6;
    localparam int HTOT = HBLK + HDUM + HFOB + HEFF + HROB;
    localparam int ODD_N = FRAME / 2;
    localparam int EVEN_N = FRAME - ODD_N;
    localparam int FRAME_CYC = FRAME * HTOT;

    typedef struct packed {
        logic       r1;
        logic [5:0] shut;
        logic       hd, vd, blk, fld, h1, h2, rg;
        logic [3:0] vph;
        logic [1:0] xg;
        logic       dr;
        logic [1:0] rgn;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic [SHUT_W-1:0] shut_lines;
    logic hd, vd, blk, fld, hclk1, hclk2, rst_gate, drain;
    logic [3:0] vph;
    logic [1:0] xfer_gate, pix_region;

    int n_chk = 0, n_fail = 0;
    int mh, ml;
    bit mf, from_rst;
    exp_t q[$];

    always #10 clk = ~clk;

    ccd_timing_gen #(
        .HBLK(HBLK), .HDUM(HDUM), .HFOB(HFOB), .HEFF(HEFF), .HROB(HROB),
        .HD_W(HD_W), .FRAME_LINES(FRAME), .VFOB(VFOB), .VEFF(VEFF),
        .VROB(VROB), .VD_LINES(VD_L), .VT_START(VT_S), .VT_STEP(VT_P),
        .RD_START(RD_S), .RD_W(RD_W), .RD_GAP(RD_G), .SUB_START(SUB_S),
        .SUB_W(SUB_W), .SHUT_W(SHUT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .shut_lines(shut_lines), .hd(hd), .vd(vd),
        .blk(blk), .fld(fld), .hclk1(hclk1), .hclk2(hclk2),
        .rst_gate(rst_gate), .vph(vph), .xfer_gate(xfer_gate),
        .drain(drain), .pix_region(pix_region)
    );

    // Expected outputs from the requirement text for one pixel position.
    function automatic exp_t model(int h, int l, bit f, int s, bit r1);
        exp_t e;
        int flen = f ? EVEN_N : ODD_N;
        int top = f ? 1 : 0;
        int d = l - top;
        int data = VFOB / 2 + VEFF / 2 + VROB / 2;
        int col, row, off, o2;
        bit shifting = (h >= HBLK);
        bit rdl = (l == flen - 1);
        bit wa, wb;
        off = h - HBLK;
        if (off < HDUM) col = 1;
        else if (off < HDUM + HFOB) col = 2;
        else if (off < HDUM + HFOB + HEFF) col = 3;
        else col = 2;
        if (l < top) row = 1;
        else if (d < VFOB / 2) row = 2;
        else if (d < VFOB / 2 + VEFF / 2) row = 3;
        else if (d < data) row = 2;
        else row = 0;
        e.r1 = r1;
        e.shut = 6'(s);
        if (!shifting || row == 0) e.rgn = 2'd0;
        else if (col == 1 || row == 1) e.rgn = 2'd1;
        else if (col == 2 || row == 2) e.rgn = 2'd2;
        else e.rgn = 2'd3;
        e.hd = (h < HD_W);
        e.blk = !shifting || (row == 0);
        e.vd = (row == 0) && (d - data < VD_L);
        e.fld = f;
        e.h1 = shifting ? (off % 2 == 0) : 1'b1;
        e.h2 = !e.h1;
        e.rg = shifting;
        e.vph = 4'b0011;
        if (!rdl && h >= VT_S && h < VT_S + 4 * VT_P) begin
            o2 = (h - VT_S) / VT_P;
            if (o2 == 0) e.vph = 4'b0110;
            else if (o2 == 1) e.vph = 4'b1100;
            else if (o2 == 2) e.vph = 4'b1001;
        end
        wa = (h >= RD_S) && (h < RD_S + RD_W);
        wb = (h >= RD_S + RD_W + RD_G) && (h < RD_S + 2 * RD_W + RD_G);
        e.xg = 2'b00;
        if (rdl) e.xg = f ? {wa, wb} : {wb, wa};
        e.dr = (s != 0) && ((flen - 1 - l) > s) && (h >= SUB_S) && (h < SUB_S + SUB_W);
        return e;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (line %0d pix %0d fld %0d)",
                     req, what, act, exp, ml, mh, mf);
        end
    endtask

    // Model counter step at a clock edge.
    task automatic advance(bit r);
        if (!r) begin
            mh = 0; ml = 0; mf = 0; from_rst = 1;
        end else begin
            from_rst = 0;
            mh++;
            if (mh == HTOT) begin
                mh = 0;
                if (ml == (mf ? EVEN_N : ODD_N) - 1) begin
                    ml = 0; mf = ~mf;
                end else ml++;
            end
        end
    endtask

    // Driver: set inputs, push expected item, wait for the next edge.
    task automatic run(int n, bit r, int s);
        for (int i = 0; i < n; i++) begin
            rst_n = r;
            shut_lines = SHUT_W'(s);
            q.push_back(model(mh, ml, mf, s, from_rst));
            @(posedge clk);
            advance(r);
            #1;
        end
    endtask

    // Monitor: pop and compare away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.r1) begin
                chk("R1", "state", {hd, blk, fld, pix_region, vph, xfer_gate},
                    {e.hd, e.blk, e.fld, e.rgn, e.vph, e.xg});
            end else begin
                chk("R2 R5", "pix_region", pix_region, e.rgn);
                chk("R3", "hd", hd, e.hd);
                chk("R3", "blk", blk, e.blk);
                chk("R4", "hclk1/hclk2/rst_gate", {hclk1, hclk2, rst_gate},
                    {e.h1, e.h2, e.rg});
                chk("R6", "fld", fld, e.fld);
                chk("R7", "vd", vd, e.vd);
                chk("R8", "vph", vph, e.vph);
                chk("R9", "xfer_gate", xfer_gate, e.xg);
                if (e.shut == 0) chk("R11", "drain", drain, e.dr);
                else             chk("R10", "drain", drain, e.dr);
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0;
        shut_lines = '0;
        mh = 0; ml = 0; mf = 0; from_rst = 1;
        @(posedge clk);
        advance(1'b0);
        #1;
        run(3, 1'b0, 0);
        run(FRAME_CYC, 1'b1, 0);
        run(FRAME_CYC, 1'b1, 3);
        run(FRAME_CYC, 1'b1, 1);
        run(FRAME_CYC, 1'b1, EVEN_N - 1);
        run(FRAME_CYC / 2 + 7, 1'b1, 40);
        run(2, 1'b0, 40);
        run(FRAME_CYC + 30, 1'b1, 5);
        @(negedge clk);
        @(negedge clk);
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired before the run ended");
        report();
    end

endmodule